// File: doc/BRIEF.md
# Descending Hardware Stack Pointer Unit

This block holds the stack pointer of a small 8-bit core and sequences every stack access onto a byte-wide data SRAM port. The stack grows downward. A push stores the byte at the current pointer and then lowers the pointer. A pop raises the pointer first and then reads the byte at the new address. Return-address saves for calls and interrupt entry store two bytes over two cycles. Restores for subroutine and interrupt return read the same two bytes back in the opposite order.

Requests arrive on a valid/ready stream. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. A source that sees `req_ready` low must hold its request, or drop it, until ready returns. `req_ready` is low only during the second cycle of a two-byte sequence, which `busy` flags. Read results appear on `rsp_valid`/`rsp_data` for one cycle. That output has no back-pressure, so the consumer must take it in that cycle. Software sees the pointer as a low and a high 8-bit register. A parameter can remove the high register, which leaves an 8-bit pointer. Software should load the pointer above 0x40 before calls or interrupts are enabled. A sticky flag reports any access at or below that guard address.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals TOP_ADDR (default 0x025F), `err` and `busy` are 0 and `req_ready` is 1.
- R2: An accepted push (req_op 0) writes req_data[7:0] at the current pointer in the accept cycle, and the pointer is one lower after that edge.
- R3: An accepted pop (req_op 1) reads address pointer+1, raises the pointer by one, and presents the byte in rsp_data[7:0] with rsp_data[15:8]=0 and rsp_valid high in the cycle after acceptance.
- R4: An accepted save (req_op 2) writes req_data[7:0] at the pointer in the accept cycle and req_data[15:8] at pointer-1 in the next cycle, lowering the pointer by two in total.
- R5: An accepted restore (req_op 3) reads pointer+1 (high byte) and then pointer+2 (low byte), raises the pointer by two, and presents {high,low} on rsp_data with rsp_valid two cycles after acceptance.
- R6: `busy` is high for exactly the one cycle after a save or restore is accepted, `req_ready` is low in that cycle, and a request presented then causes no memory access and no pointer change.
- R7: io_rdata shows the pointer low byte when io_sel=0 and the high byte when io_sel=1. A write with io_we loads the selected byte at the next edge and takes priority over a stack step in the same cycle.
- R8: `err` becomes 1 in the cycle after any memory access whose address is at or below GUARD_ADDR (0x40) and stays set. An io write with io_sel=0 clears it, except that a guard hit in the same cycle wins.
- R9: With HIGH_REG=0 the pointer is 8 bits wide, io_rdata reads 0 when io_sel=1, and high-byte writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Stack request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 2 | 0 push, 1 pop, 2 save address, 3 restore address |
| req_data | input | 16 | Push byte in [7:0]; return address for save |
| rsp_valid | output | 1 | Read result valid for this cycle |
| rsp_data | output | 16 | Popped byte (zero-extended) or restored address |
| busy | output | 1 | Second cycle of a two-byte sequence |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | PTR_W | SRAM byte address |
| mem_wdata | output | 8 | SRAM write byte |
| mem_rdata | input | 8 | SRAM read byte, one cycle after the address |
| io_we | input | 1 | Pointer register write strobe |
| io_sel | input | 1 | 0 low byte, 1 high byte |
| io_wdata | input | 8 | Pointer register write byte |
| io_rdata | output | 8 | Selected pointer byte |
| err | output | 1 | Sticky guard-address violation |

## Verification
The embedded assertions check on every cycle the one-step pointer change after a push, the response timing of pops and restores, the single-cycle length of `busy` with a write in the save tail, and the setting of `err` after any access to a guarded address. Some things only the bench scenarios can show. These are the actual bytes in SRAM and their order, the reassembled restore value, that a request offered while busy does nothing, the priority of a register write over a stack step and of a guard hit over a clear, and the behaviour of the variant without a high register.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_SAVE    = 2'd2,
    OP_RESTORE = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAVE_HI = 2'd1,
    ST_REST_LO = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int PTR_W    = 16,
  parameter int TOP_ADDR = 16'h025F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             inc,
  input  logic             io_we,
  input  logic             io_sel,
  input  logic [7:0]       io_wdata,
  output logic [PTR_W-1:0] sp,
  output logic [7:0]       io_rdata
);
  localparam logic [PTR_W-1:0] TOP = TOP_ADDR[PTR_W-1:0];

  generate
    if (PTR_W > 8) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp <= TOP;
        else if (io_we) begin
          if (io_sel) sp[PTR_W-1:8] <= io_wdata[PTR_W-9:0];
          else        sp[7:0]       <= io_wdata;
        end
        else if (dec) sp <= sp - 1'b1;
        else if (inc) sp <= sp + 1'b1;
      end
      always_comb begin
        io_rdata = 8'h00;
        if (io_sel) io_rdata[PTR_W-9:0] = sp[PTR_W-1:8];
        else        io_rdata = sp[7:0];
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp <= TOP;
        else if (io_we) begin
          if (!io_sel) sp <= io_wdata;
        end
        else if (dec) sp <= sp - 1'b1;
        else if (inc) sp <= sp + 1'b1;
      end
      assign io_rdata = io_sel ? 8'h00 : sp;
    end
  endgenerate
endmodule

// File: rtl/stk_sequencer.sv
module stk_sequencer
  import stk_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] sp,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_data,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic             busy,
  output logic             dec,
  output logic             inc,
  output logic             mem_en,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  stk_state_e state, state_nx;
  logic [7:0] save_hi_q, rest_hi_q;
  logic       pop_pend, rest_pend;
  logic       take;
  stk_op_e    op;

  assign op        = stk_op_e'(req_op);
  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  always_comb begin
    state_nx  = state;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = 8'h00;
    dec       = 1'b0;
    inc       = 1'b0;
    unique case (state)
      ST_IDLE: if (take) begin
        mem_en = 1'b1;
        unique case (op)
          OP_PUSH: begin
            mem_we = 1'b1; mem_wdata = req_data[7:0]; dec = 1'b1;
          end
          OP_POP: begin
            mem_addr = sp + 1'b1; inc = 1'b1;
          end
          OP_SAVE: begin
            mem_we = 1'b1; mem_wdata = req_data[7:0]; dec = 1'b1;
            state_nx = ST_SAVE_HI;
          end
          OP_RESTORE: begin
            mem_addr = sp + 1'b1; inc = 1'b1;
            state_nx = ST_REST_LO;
          end
        endcase
      end
      ST_SAVE_HI: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_wdata = save_hi_q; dec = 1'b1;
        state_nx = ST_IDLE;
      end
      ST_REST_LO: begin
        mem_en = 1'b1; mem_addr = sp + 1'b1; inc = 1'b1;
        state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      save_hi_q <= 8'h00;
      rest_hi_q <= 8'h00;
      pop_pend  <= 1'b0;
      rest_pend <= 1'b0;
    end else begin
      state     <= state_nx;
      pop_pend  <= (state == ST_IDLE) && take && (op == OP_POP);
      rest_pend <= (state == ST_REST_LO);
      if ((state == ST_IDLE) && take && (op == OP_SAVE)) save_hi_q <= req_data[15:8];
      if (state == ST_REST_LO) rest_hi_q <= mem_rdata;
    end
  end

  assign rsp_valid = pop_pend || rest_pend;
  assign rsp_data  = rest_pend ? {rest_hi_q, mem_rdata} : {8'h00, mem_rdata};

  // R6
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R4
  save_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAVE_HI) |-> (mem_en && mem_we && mem_addr == sp));
endmodule

// File: rtl/stk_guard.sv
module stk_guard #(
  parameter int PTR_W      = 16,
  parameter int GUARD_ADDR = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [PTR_W-1:0] addr,
  input  logic             clr,
  output logic             err
);
  localparam logic [PTR_W-1:0] GUARD = GUARD_ADDR[PTR_W-1:0];
  logic hit;
  assign hit = acc && (addr <= GUARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err <= 1'b0;
    else if (hit) err <= 1'b1;
    else if (clr) err <= 1'b0;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int HIGH_REG   = 1,
  parameter int TOP_ADDR   = 16'h025F,
  parameter int GUARD_ADDR = 16'h0040,
  localparam int PTR_W     = (HIGH_REG != 0) ? 16 : 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_data,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic             busy,
  output logic             mem_en,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             io_we,
  input  logic             io_sel,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             err
);
  localparam logic [PTR_W-1:0] GUARD = GUARD_ADDR[PTR_W-1:0];
  logic [PTR_W-1:0] sp;
  logic             dec, inc;

  stk_pointer #(.PTR_W(PTR_W), .TOP_ADDR(TOP_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec(dec), .inc(inc),
    .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .sp(sp), .io_rdata(io_rdata)
  );

  stk_sequencer #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sp(sp),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .dec(dec), .inc(inc),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  stk_guard #(.PTR_W(PTR_W), .GUARD_ADDR(GUARD_ADDR)) u_guard (
    .clk(clk), .rst_n(rst_n), .acc(mem_en), .addr(mem_addr),
    .clr(io_we && !io_sel), .err(err)
  );

  logic take;
  assign take = req_valid && req_ready;

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd0 && !io_we) |=> (sp == $past(sp) - 1'b1));
  // R3
  pop_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd1) |=> (rsp_valid && rsp_data[15:8] == 8'h00));
  // R5
  rest_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd3) |=> (!rsp_valid && busy) ##1 rsp_valid);
  // R8
  guard_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_addr <= GUARD) |=> err);
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_data = 16'h0;
  logic        rsp_valid, busy, mem_en, mem_we, err;
  logic [15:0] rsp_data, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_rdata;
  logic        io_we = 1'b0, io_sel = 1'b0;
  logic [7:0]  io_wdata = 8'h0;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_we(io_we), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .err(err)
  );

  // narrow variant, register access only
  logic       n_ready, n_rv, n_busy, n_en, n_we, n_err;
  logic [15:0] n_rd;
  logic [7:0] n_addr, n_wd, n_io_rdata;
  logic       n_io_we = 1'b0, n_io_sel = 1'b0;
  logic [7:0] n_io_wdata = 8'h0;
  stack_ptr_unit #(.HIGH_REG(0), .TOP_ADDR(8'hF0)) i_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(n_ready),
    .req_op(2'd0), .req_data(16'h0), .rsp_valid(n_rv), .rsp_data(n_rd),
    .busy(n_busy), .mem_en(n_en), .mem_we(n_we), .mem_addr(n_addr),
    .mem_wdata(n_wd), .mem_rdata(8'h00), .io_we(n_io_we), .io_sel(n_io_sel),
    .io_wdata(n_io_wdata), .io_rdata(n_io_rdata), .err(n_err)
  );

  // SRAM model, one-cycle read latency
  logic [7:0] ram [0:1023];
  initial for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    if (mem_en) mem_rdata <= ram[mem_addr[9:0]];
  end

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare read results with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R3/R5 unexpected rsp", rsp_data, 32'hFFFF_FFFF);
      else check("R3/R5 rsp_data", rsp_data, exp_q.pop_front());
    end
  end

  task automatic issue(logic [1:0] op, logic [15:0] data, logic [15:0] exp_rsp);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = data;
    if (op == 2'd1 || op == 2'd3) exp_q.push_back(exp_rsp);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (op >= 2'd2) @(negedge clk);
  endtask

  task automatic io_write(logic sel, logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_sel = sel; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic read_sp(output logic [15:0] v);
    io_sel = 1'b0; #1; v[7:0] = io_rdata;
    io_sel = 1'b1; #1; v[15:8] = io_rdata;
    io_sel = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_sp(v);
    check("R1 sp", v, 16'h025F);
    check("R1 err/busy/ready", {err, busy, req_ready}, 3'b001);

    issue(2'd0, 16'h00A1, 16'h0);
    issue(2'd0, 16'h00B2, 16'h0);
    check("R2 byte at 25F", ram[10'h25F], 8'hA1);
    check("R2 byte at 25E", ram[10'h25E], 8'hB2);
    read_sp(v); check("R2 sp", v, 16'h025D);

    issue(2'd1, 16'h0, 16'h00B2);
    issue(2'd1, 16'h0, 16'h00A1);
    read_sp(v); check("R3 sp", v, 16'h025F);

    // save, with a push offered during the busy cycle
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_data = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    check("R6 busy/ready", {busy, req_ready}, 2'b10);
    req_op = 2'd0; req_data = 16'h0077;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 low byte", ram[10'h25F], 8'h34);
    check("R4 high byte", ram[10'h25E], 8'h12);
    check("R6 ignored push mem", ram[10'h25D], 8'h00);
    read_sp(v); check("R4/R6 sp", v, 16'h025D);

    issue(2'd3, 16'h0, 16'h1234);
    @(negedge clk);
    read_sp(v); check("R5 sp", v, 16'h025F);

    // guard checks
    io_write(1'b1, 8'h00);
    io_write(1'b0, 8'h42);
    read_sp(v); check("R7 io write", v, 16'h0042);
    issue(2'd0, 16'h0011, 16'h0);
    issue(2'd0, 16'h0022, 16'h0);
    check("R8 no err above guard", err, 1'b0);
    issue(2'd0, 16'h0033, 16'h0);
    check("R8 err at guard", err, 1'b1);
    issue(2'd0, 16'h0044, 16'h0);
    check("R8 sticky", err, 1'b1);
    io_write(1'b0, 8'h40);
    check("R8 cleared", err, 1'b0);
    // push at 0x40 together with a low-byte write
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_data = 16'h0055;
    io_we = 1'b1; io_sel = 1'b0; io_wdata = 8'h90;
    @(negedge clk);
    req_valid = 1'b0; io_we = 1'b0;
    check("R8 set wins", err, 1'b1);
    check("R7 write priority mem", ram[10'h040], 8'h55);
    read_sp(v); check("R7 write priority sp", v, 16'h0090);
    io_write(1'b0, 8'h91);
    check("R8 clear again", err, 1'b0);

    // narrow variant
    n_io_sel = 1'b0; #1; check("R9 narrow low", n_io_rdata, 8'hF0);
    @(negedge clk);
    n_io_we = 1'b1; n_io_sel = 1'b1; n_io_wdata = 8'h55;
    @(negedge clk);
    n_io_we = 1'b0; #1;
    check("R9 narrow high", n_io_rdata, 8'h00);
    n_io_sel = 1'b0; #1; check("R9 narrow low kept", n_io_rdata, 8'hF0);

    repeat (3) @(negedge clk);
    check("R3/R5 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule